// File: doc/BRIEF.md
# Delay-Tap Phase Calibration Controller

This controller finds a fixed sampling delay for each of a large set of serial receive lanes. The receiver and the transmitter run from one frequency reference, so each lane differs only by a phase offset that does not change. That offset can be found once, during a training period in which the transmitter repeats a known pattern, and then held. An external checker watches each lane and raises a per-lane "pattern good" line. An external variable delay element sits in front of each lane's sampler.

After a start pulse the controller visits the lanes one after another. For the current lane it writes every delay tap in turn over a write bus. After each write it waits a fixed settle time. It then watches that lane's "pattern good" line for a fixed number of words, one word per clock, and marks the tap as passing only if every word was good. While it sweeps, it tracks the longest run of adjacent passing taps and keeps the tap at the centre of that run in a per-lane register. A lane with no passing tap gets its failure flag set and a setting of tap 0.

When the last lane is finished, the controller writes every stored setting back to its lane, raises done and waits for the next start pulse.

Top module: `phase_cal_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `done_o` and `tap_we_o` are low, `chan_sel_o` is 0 and `fail_o` is all zeros.
- R2: A start pulse accepted while idle or done begins a sweep. Lanes are visited in ascending order from 0. For each lane, taps 0 to TAPS-1 are written in ascending order, one `tap_we_o` write per tap. Each write is addressed by `chan_sel_o`, which equals the lane under calibration.
- R3: During the SETTLE_CYC cycles that follow each tap write, the value of `pat_ok_i` has no effect on the result.
- R4: A tap passes only if the selected lane's `pat_ok_i` is high on each of the OBS_WORDS cycles that follow the settle time. A single low word fails the tap.
- R5: A lane's stored setting is start + (len-1)/2, rounded down, where start and len describe the longest run of adjacent passing taps. Runs do not wrap from the last tap to tap 0.
- R6: When two or more runs share the longest length, the run with the lowest starting tap is used.
- R7: A lane with no passing tap gets its bit in `fail_o` set, and its stored setting is 0.
- R8: After the last lane is swept, exactly one write per lane is issued in ascending lane order. Each write carries that lane's stored setting. After these writes `done_o` rises, and no write occurs while `done_o` is high.
- R9: `done_o` stays high until a start pulse arrives. Start pulses during a sweep or during the write-back phase are ignored.
- R10: Only the `pat_ok_i` bit of the lane shown on `chan_sel_o` affects that lane's result.
- R11: A start pulse while done is high drops `done_o` on the next cycle and runs a full new calibration. Each lane's fail flag is rewritten with that run's outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a calibration run |
| pat_ok_i | input | NUM_CH | Per-lane training-pattern word good, one word per clock |
| chan_sel_o | output | $clog2(NUM_CH) | Lane under calibration; also the address of a tap write |
| tap_we_o | output | 1 | Delay tap write strobe |
| tap_val_o | output | $clog2(TAPS) | Tap value written to lane `chan_sel_o` |
| done_o | output | 1 | Calibration complete and settings applied |
| fail_o | output | NUM_CH | Per-lane flag: no passing tap found |

## Verification
The assertions assume two things. First, the pattern-good input reflects the newly written tap only after the settle time. Second, start is a short pulse rather than being held during a run, because the done-hold property treats start as the only way out of done. The bench drives each lane's pattern-good line from a model of the delay register written over the tap bus. That model defines the line from a per-tap mode: always bad, always good, toggling every clock, or bad only during settle. Lanes that are not selected see unrelated toggling, which keeps every input inside these assumptions while exercising the lane mux.

// File: rtl/phase_cal_pkg.sv
package phase_cal_pkg;

  typedef enum logic [2:0] {
    CAL_IDLE,
    CAL_LOAD,
    CAL_DWELL,
    CAL_STORE,
    CAL_APPLY,
    CAL_DONE
  } cal_state_e;

  typedef enum logic [1:0] {
    DW_OFF,
    DW_SETTLE,
    DW_OBSERVE
  } dwell_phase_e;

endpackage

// File: rtl/phase_cal_dwell.sv
module phase_cal_dwell
  import phase_cal_pkg::*;
#(
  parameter int SETTLE_CYC = 8,
  parameter int OBS_WORDS  = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic pat_ok_i,
  output logic done_o,
  output logic pass_o
);
  localparam int MAXC = (SETTLE_CYC > OBS_WORDS) ? SETTLE_CYC : OBS_WORDS;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] OBS_LAST    = CW'(OBS_WORDS - 1);

  dwell_phase_e phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic ok_q, ok_d, done_q, done_d, pass_q, pass_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    ok_d    = ok_q;
    done_d  = 1'b0;
    pass_d  = pass_q;
    unique case (phase_q)
      DW_OFF: begin
        if (start_i) begin
          phase_d = DW_SETTLE;
          cnt_d   = '0;
        end
      end
      DW_SETTLE: begin
        if (cnt_q == SETTLE_LAST) begin
          phase_d = DW_OBSERVE;
          cnt_d   = '0;
          ok_d    = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      DW_OBSERVE: begin
        ok_d = ok_q & pat_ok_i;
        if (cnt_q == OBS_LAST) begin
          phase_d = DW_OFF;
          done_d  = 1'b1;
          pass_d  = ok_q & pat_ok_i;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: phase_d = DW_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= DW_OFF;
      cnt_q   <= '0;
      ok_q    <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      ok_q    <= ok_d;
      done_q  <= done_d;
      pass_q  <= pass_d;
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;

  // R3: a new dwell is only requested when the previous one has finished
  assert_start_when_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> phase_q == DW_OFF);

  // R4: the verdict strobe lasts a single cycle
  assert_verdict_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/phase_cal_window.sv
module phase_cal_window #(
  parameter int TAPS = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     upd_i,
  input  logic                     pass_i,
  input  logic [$clog2(TAPS)-1:0]  tap_i,
  output logic                     any_o,
  output logic [$clog2(TAPS)-1:0]  mid_o
);
  localparam int TW = $clog2(TAPS);
  localparam int LW = $clog2(TAPS + 1);

  logic [TW-1:0] cur_start_q, cur_start_d, best_start_q, best_start_d;
  logic [LW-1:0] cur_len_q, cur_len_d, best_len_q, best_len_d;
  logic [LW-1:0] run_len_nx, half_len;
  logic [TW-1:0] run_start_nx;
  logic          grow, trk_en;

  always_comb begin
    run_len_nx   = cur_len_q + 1'b1;
    run_start_nx = (cur_len_q == '0) ? tap_i : cur_start_q;
    grow         = pass_i && (run_len_nx > best_len_q);
    trk_en       = clr_i | upd_i;
    cur_start_d  = cur_start_q;
    cur_len_d    = cur_len_q;
    best_start_d = best_start_q;
    best_len_d   = best_len_q;
    if (clr_i) begin
      cur_start_d  = '0;
      cur_len_d    = '0;
      best_start_d = '0;
      best_len_d   = '0;
    end else if (upd_i) begin
      if (pass_i) begin
        cur_start_d = run_start_nx;
        cur_len_d   = run_len_nx;
        if (grow) begin
          best_start_d = run_start_nx;
          best_len_d   = run_len_nx;
        end
      end else begin
        cur_len_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else if (trk_en) begin
      cur_start_q  <= cur_start_d;
      cur_len_q    <= cur_len_d;
      best_start_q <= best_start_d;
      best_len_q   <= best_len_d;
    end
  end

  always_comb begin
    half_len = (best_len_q - 1'b1) >> 1;
    any_o    = best_len_q != '0;
    mid_o    = best_start_q + TW'(half_len);
  end

  // R5: without a clear the best run only grows
  assert_best_never_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> best_len_q >= $past(best_len_q));

  // R5: a run never exceeds the tap count
  assert_run_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_len_q <= LW'(TAPS)) && (best_len_q <= LW'(TAPS)));

  // R6: updates and clears never collide
  assert_no_clear_during_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_i && upd_i));

endmodule

// File: rtl/phase_cal_store.sv
module phase_cal_store #(
  parameter int NUM_CH = 96,
  parameter int TAPS   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_i,
  input  logic [$clog2(NUM_CH)-1:0]  wr_ch_i,
  input  logic [$clog2(TAPS)-1:0]    wr_tap_i,
  input  logic                       wr_fail_i,
  input  logic [$clog2(NUM_CH)-1:0]  rd_ch_i,
  output logic [$clog2(TAPS)-1:0]    rd_tap_o,
  output logic [NUM_CH-1:0]          fail_o
);
  localparam int TW = $clog2(TAPS);

  logic [TW-1:0]     setting_q [NUM_CH];
  logic [NUM_CH-1:0] fail_q;

  always_ff @(posedge clk) begin
    if (wr_i) setting_q[wr_ch_i] <= wr_tap_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fail_q          <= '0;
    else if (wr_i) fail_q[wr_ch_i] <= wr_fail_i;
  end

  assign rd_tap_o = setting_q[rd_ch_i];
  assign fail_o   = fail_q;

  // R7: a failing lane is always recorded with tap 0
  assert_fail_stores_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wr_fail_i) |-> wr_tap_i == '0);

  // R2: writes address an existing lane
  assert_lane_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |-> int'(wr_ch_i) < NUM_CH);

endmodule

// File: rtl/phase_cal_ctrl.sv
module phase_cal_ctrl
  import phase_cal_pkg::*;
#(
  parameter int NUM_CH     = 96,
  parameter int TAPS       = 32,
  parameter int SETTLE_CYC = 8,
  parameter int OBS_WORDS  = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [NUM_CH-1:0]          pat_ok_i,
  output logic [$clog2(NUM_CH)-1:0]  chan_sel_o,
  output logic                       tap_we_o,
  output logic [$clog2(TAPS)-1:0]    tap_val_o,
  output logic                       done_o,
  output logic [NUM_CH-1:0]          fail_o
);
  localparam int CHW = $clog2(NUM_CH);
  localparam int TW  = $clog2(TAPS);
  localparam logic [CHW-1:0] CH_LAST  = CHW'(NUM_CH - 1);
  localparam logic [TW-1:0]  TAP_LAST = TW'(TAPS - 1);

  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cal_state_e     state_q, state_d;
  logic [CHW-1:0] ch_q, ch_d;
  logic [TW-1:0]  tap_q, tap_d;
  logic           ch_en, tap_en;

  logic          sel_ok, dw_start, dw_done, dw_pass;
  logic          win_clr, win_any;
  logic [TW-1:0] win_mid, store_tap, rd_tap;
  logic          store_wr, accept;

  assign sel_ok   = pat_ok_i[ch_q];
  assign accept   = start_i && (state_q == CAL_IDLE || state_q == CAL_DONE);
  assign dw_start = (state_q == CAL_LOAD);
  assign store_wr = (state_q == CAL_STORE);
  assign win_clr  = accept || store_wr;
  assign store_tap = win_any ? win_mid : '0;

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    tap_d   = tap_q;
    ch_en   = 1'b0;
    tap_en  = 1'b0;
    unique case (state_q)
      CAL_IDLE, CAL_DONE: begin
        if (start_i) begin
          state_d = CAL_LOAD;
          ch_d    = '0;
          tap_d   = '0;
          ch_en   = 1'b1;
          tap_en  = 1'b1;
        end
      end
      CAL_LOAD: state_d = CAL_DWELL;
      CAL_DWELL: begin
        if (dw_done) begin
          if (tap_q == TAP_LAST) begin
            state_d = CAL_STORE;
          end else begin
            state_d = CAL_LOAD;
            tap_d   = tap_q + 1'b1;
            tap_en  = 1'b1;
          end
        end
      end
      CAL_STORE: begin
        ch_en = 1'b1;
        if (ch_q == CH_LAST) begin
          state_d = CAL_APPLY;
          ch_d    = '0;
        end else begin
          state_d = CAL_LOAD;
          ch_d    = ch_q + 1'b1;
          tap_d   = '0;
          tap_en  = 1'b1;
        end
      end
      CAL_APPLY: begin
        if (ch_q == CH_LAST) begin
          state_d = CAL_DONE;
        end else begin
          ch_d  = ch_q + 1'b1;
          ch_en = 1'b1;
        end
      end
      default: state_d = CAL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      state_q <= CAL_IDLE;
      ch_q    <= '0;
      tap_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ch_en)  ch_q  <= ch_d;
      if (tap_en) tap_q <= tap_d;
    end
  end

  phase_cal_dwell #(.SETTLE_CYC(SETTLE_CYC), .OBS_WORDS(OBS_WORDS)) u_dwell (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .start_i  (dw_start),
    .pat_ok_i (sel_ok),
    .done_o   (dw_done),
    .pass_o   (dw_pass)
  );

  phase_cal_window #(.TAPS(TAPS)) u_window (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .clr_i  (win_clr),
    .upd_i  (dw_done),
    .pass_i (dw_pass),
    .tap_i  (tap_q),
    .any_o  (win_any),
    .mid_o  (win_mid)
  );

  phase_cal_store #(.NUM_CH(NUM_CH), .TAPS(TAPS)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .wr_i      (store_wr),
    .wr_ch_i   (ch_q),
    .wr_tap_i  (store_tap),
    .wr_fail_i (!win_any),
    .rd_ch_i   (ch_q),
    .rd_tap_o  (rd_tap),
    .fail_o    (fail_o)
  );

  assign chan_sel_o = ch_q;
  assign tap_we_o   = (state_q == CAL_LOAD) || (state_q == CAL_APPLY);
  assign tap_val_o  = (state_q == CAL_APPLY) ? rd_tap : tap_q;
  assign done_o     = (state_q == CAL_DONE);

  // R9: done holds until a start pulse
  assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (done_o && !start_i) |=> done_o);

  // R11: start while done clears done and issues the first tap write
  assert_restart_clears_done_R11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (done_o && start_i) |=> (!done_o && tap_we_o));

  // R8: the bus is quiet while done is high
  assert_quiet_when_done_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    done_o |-> !tap_we_o);

  // R8: done rises only right after a write-back write
  assert_done_after_apply_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(done_o) |-> $past(tap_we_o));

  // R2: lane select is stable while a tap dwell is in progress
  assert_lane_stable_in_dwell_R2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (state_q == CAL_DWELL) |=> $stable(chan_sel_o));

endmodule

// File: tb/phase_cal_ctrl_tb.sv
module phase_cal_ctrl_tb;
  localparam int NCH = 4;
  localparam int NT  = 8;
  localparam int NS  = 3;
  localparam int NW  = 5;
  localparam int NSC = 3;

  // per lane 16 bits, tap t mode at bits [2t+1:2t]; lane c at [16c+15:16c]
  // mode 0 always bad, 1 always good, 2 toggles each clock, 3 bad only in settle
  localparam logic [63:0] VEC_MODE [NSC] = '{
    {16'h1505, 16'h0000, 16'h5555, 16'h0550},
    {16'h4000, 16'h1594, 16'h3FC0, 16'h1405},
    {16'h0574, 16'h0001, 16'h5000, 16'hAAAA}
  };
  // expected settings, 3 bits per lane, lane c at [3c+2:3c]
  localparam logic [11:0] VEC_SET [NSC] = '{
    {3'd5, 3'd0, 3'd3, 3'd3},
    {3'd7, 3'd5, 3'd4, 3'd0},
    {3'd3, 3'd0, 3'd6, 3'd0}
  };
  localparam logic [3:0] VEC_FAIL [NSC] = '{4'b0100, 4'b0000, 4'b0001};

  logic clk = 1'b0;
  logic rst_n, start;
  logic [NCH-1:0] pat_ok;
  logic [1:0] chan_sel;
  logic tap_we, done;
  logic [2:0] tap_val;
  logic [NCH-1:0] fail;

  always #2.5 clk = ~clk;

  phase_cal_ctrl #(.NUM_CH(NCH), .TAPS(NT), .SETTLE_CYC(NS), .OBS_WORDS(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .pat_ok_i(pat_ok),
    .chan_sel_o(chan_sel), .tap_we_o(tap_we), .tap_val_o(tap_val),
    .done_o(done), .fail_o(fail)
  );

  int n_chk = 0, n_bad = 0;
  logic [2:0]  dly [NCH];
  logic [63:0] modes = '0;
  logic [11:0] exp_set = '0;
  int cnt = 0, cyc = 0, widx = 0, sweep_err = 0, apply_err = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // delay register model and write-order monitor
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (tap_we) begin
      dly[chan_sel] <= tap_val;
      cnt <= 0;
      if (widx < NCH*NT) begin
        if (int'(chan_sel) != widx / NT || int'(tap_val) != widx % NT) sweep_err <= sweep_err + 1;
      end else begin
        if (int'(chan_sel) != widx - NCH*NT ||
            tap_val != exp_set[3*(widx-NCH*NT) +: 3]) apply_err <= apply_err + 1;
      end
      widx <= widx + 1;
    end else begin
      cnt <= cnt + 1;
    end
  end

  // R10: unselected lanes carry unrelated toggling
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      if (c == int'(chan_sel)) begin
        case (modes[16*c + 2*int'(dly[c]) +: 2])
          2'd0: pat_ok[c] = 1'b0;
          2'd1: pat_ok[c] = 1'b1;
          2'd2: pat_ok[c] = cyc[0];
          default: pat_ok[c] = (cnt > NS);
        endcase
      end else begin
        pat_ok[c] = cyc[1];
      end
    end
  end

  task automatic run_scenario(input int s, input bit poke_busy);
    int waited;
    modes = VEC_MODE[s];
    exp_set = VEC_SET[s];
    @(negedge clk);
    widx = 0; sweep_err = 0; apply_err = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!done, "R11 done drops after start", int'(done), 0);
    if (poke_busy) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (NCH*NT*(NS+NW+2) - 50) @(negedge clk);
      start = 1'b1;   // lands in the sweep of the last lane or write-back
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    check(done == 1'b1, "R8 done reached", int'(done), 1);
    check(sweep_err == 0, "R2 sweep order", sweep_err, 0);
    check(apply_err == 0, "R8 write-back order and values", apply_err, 0);
    check(widx == NCH*NT + NCH, "R2 R8 R9 write count", widx, NCH*NT + NCH);
    for (int c = 0; c < NCH; c++)
      check(dly[c] == exp_set[3*c +: 3], "R3 R4 R5 R6 R10 lane setting",
            int'(dly[c]), int'(exp_set[3*c +: 3]));
    check(fail == VEC_FAIL[s], "R7 R11 fail flags", int'(fail), int'(VEC_FAIL[s]));
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    for (int c = 0; c < NCH; c++) dly[c] = '0;
    repeat (3) @(negedge clk);
    check(!done && !tap_we && chan_sel == 0 && fail == 0, "R1 state in reset",
          int'({done, tap_we, chan_sel, fail}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!done && !tap_we && chan_sel == 0 && fail == 0, "R1 state after reset",
          int'({done, tap_we, chan_sel, fail}), 0);

    for (int s = 0; s < NSC; s++) run_scenario(s, 1'b0);

    // R9: done holds without start and the bus stays quiet
    begin
      int w0;
      w0 = widx;
      repeat (25) @(negedge clk);
      check(done == 1'b1, "R9 done held", int'(done), 1);
      check(widx == w0, "R9 no writes while done", widx - w0, 0);
    end

    // R9: start pulses during a run are ignored
    run_scenario(0, 1'b1);
    // R11: rerun after a busy-poked run
    run_scenario(1, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule